// File: doc/BRIEF.md
# Dual-Lane Packed Add/Subtract Unit

This unit performs packed arithmetic on a 64-bit datapath. Each operand is viewed as two independent 32-bit lanes. A 4-bit operation code selects one of ten lane functions:

- plain add and subtract that wrap around;
- add and subtract that clamp to the signed or unsigned range;
- halving add and subtract, signed or unsigned. These form the sum or difference with one extra bit and then drop the lowest bit, so a lane cannot overflow.

Both lanes always use the same function. A carry or borrow never moves from one lane into the other.

The arithmetic is combinational. By default it feeds one output register. That register loads when `in_valid` is high and holds its value otherwise. `out_valid` is `in_valid` delayed by one clock. A parameter can remove the register and leave a purely combinational path.

Top module: `simd_dual_lane_alu`

## Requirements
- R1: Lane 0 is bits 31:0 and lane 1 is bits 63:32. Opcode 0 gives a+b modulo 2^32 per lane, and opcode 1 gives a-b modulo 2^32 per lane. No carry or borrow passes between the lanes.
- R2: Opcode 2 is a signed add that clamps the lane to the range -2^31 to 2^31-1. Opcode 4 is a signed subtract with the same clamp. A clamped result takes the extreme value on the side of the first operand's sign. For example, 0x80000000+0x80000000 gives 0x80000000, and 0x7FFFFFFF-0xFFFFFFFF gives 0x7FFFFFFF.
- R3: Opcode 3 is an unsigned add that clamps at 0xFFFFFFFF. Opcode 5 is an unsigned subtract that clamps at 0.
- R4: Opcode 6 sign-extends both lanes, adds them and shifts right arithmetically by one. The result rounds toward minus infinity, so the halving sum of -1 and 0 is -1.
- R5: Opcode 7 gives the floor of the unsigned mean of the two lanes and never overflows.
- R6: Opcode 8 sign-extends both lanes, subtracts them, shifts right arithmetically by one and keeps the low 32 bits.
- R7: Opcode 9 zero-extends both lanes to 33 bits, subtracts them and shifts right logically by one. When a<b the borrow appears in bit 31, so 0-1 gives 0xFFFFFFFF.
- R8: Opcodes 10 to 15 give an all-zero result.
- R9: When `in_valid` is high at a rising clock edge, `result` and `out_valid`=1 appear after that edge. `out_valid` is low after any edge at which `in_valid` was low.
- R10: While `in_valid` is low, `result` keeps its last value whatever the operands and the opcode do.
- R11: While `rst_n` is low, `result` is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 4 | Lane function select |
| src_a | input | 64 | First operand, two packed lanes |
| src_b | input | 64 | Second operand, two packed lanes |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Packed lane results |

## Verification
The assertions assume the default registered variant. They also assume that `op`, `src_a` and `src_b` are known values whenever `in_valid` is high outside reset, because several properties look back at those inputs one cycle later. The bench changes inputs only on the falling clock edge and drives every input on every cycle. Random operands are biased toward 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF so that the clamp and borrow paths are exercised often.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD      = 4'd0,
    OP_SUB      = 4'd1,
    OP_SADD_SAT = 4'd2,
    OP_UADD_SAT = 4'd3,
    OP_SSUB_SAT = 4'd4,
    OP_USUB_SAT = 4'd5,
    OP_SAVG_ADD = 4'd6,
    OP_UAVG_ADD = 4'd7,
    OP_SAVG_SUB = 4'd8,
    OP_UAVG_SUB = 4'd9
  } simd_op_e;

  localparam int NUM_OPS = 10;

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y,
  output logic            sat_hi,
  output logic            sat_lo
);

  localparam logic [W-1:0] UMAX = {W{1'b1}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  // Arithmetic at one extra bit of precision
  function automatic logic [W:0] f_sext_add(input logic [W-1:0] x, input logic [W-1:0] z);
    return {x[W-1], x} + {z[W-1], z};
  endfunction

  function automatic logic [W:0] f_sext_sub(input logic [W-1:0] x, input logic [W-1:0] z);
    return {x[W-1], x} - {z[W-1], z};
  endfunction

  function automatic logic [W:0] f_zext_add(input logic [W-1:0] x, input logic [W-1:0] z);
    return {1'b0, x} + {1'b0, z};
  endfunction

  function automatic logic [W:0] f_zext_sub(input logic [W-1:0] x, input logic [W-1:0] z);
    return {1'b0, x} - {1'b0, z};
  endfunction

  // Floor of the unsigned mean without a wider adder
  function automatic logic [W-1:0] f_umean(input logic [W-1:0] x, input logic [W-1:0] z);
    return (x & z) + ((x ^ z) >> 1);
  endfunction

  simd_op_e   opc;
  logic [W:0] s_add, s_sub, u_add, u_sub;
  logic       sadd_ovf, ssub_ovf;

  assign opc   = simd_op_e'(op);
  assign s_add = f_sext_add(a, b);
  assign s_sub = f_sext_sub(a, b);
  assign u_add = f_zext_add(a, b);
  assign u_sub = f_zext_sub(a, b);

  // Signed overflow: operand signs agree (add) or differ (sub),
  // and the wrapped sign departs from the first operand
  assign sadd_ovf = (a[W-1] == b[W-1]) && (s_add[W-1] != a[W-1]);
  assign ssub_ovf = (a[W-1] != b[W-1]) && (s_sub[W-1] != a[W-1]);

  always_comb begin
    y      = '0;
    sat_hi = 1'b0;
    sat_lo = 1'b0;
    case (opc)
      OP_ADD: y = u_add[W-1:0];
      OP_SUB: y = u_sub[W-1:0];
      OP_SADD_SAT: begin
        if (sadd_ovf) begin
          y      = a[W-1] ? SMIN : SMAX;
          sat_hi = !a[W-1];
          sat_lo = a[W-1];
        end else begin
          y = s_add[W-1:0];
        end
      end
      OP_UADD_SAT: begin
        if (u_add[W]) begin
          y      = UMAX;
          sat_hi = 1'b1;
        end else begin
          y = u_add[W-1:0];
        end
      end
      OP_SSUB_SAT: begin
        if (ssub_ovf) begin
          y      = a[W-1] ? SMIN : SMAX;
          sat_hi = !a[W-1];
          sat_lo = a[W-1];
        end else begin
          y = s_sub[W-1:0];
        end
      end
      OP_USUB_SAT: begin
        if (u_sub[W]) begin
          y      = '0;
          sat_lo = 1'b1;
        end else begin
          y = u_sub[W-1:0];
        end
      end
      OP_SAVG_ADD: y = s_add[W:1];
      OP_UAVG_ADD: y = f_umean(a, b);
      OP_SAVG_SUB: y = s_sub[W:1];
      OP_UAVG_SUB: y = u_sub[W:1];
      default:     y = '0;
    endcase
  end

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] d,
  output logic         out_valid,
  output logic [W-1:0] q
);

  if (REG_OUT) begin : g_reg
    logic [W-1:0] q_r;
    logic         v_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= '0;
        v_r <= 1'b0;
      end else begin
        v_r <= in_valid;
        if (in_valid) q_r <= d;
      end
    end

    assign q         = q_r;
    assign out_valid = v_r;
  end else begin : g_comb
    assign q         = d;
    assign out_valid = in_valid;
  end

endmodule

// File: rtl/simd_dual_lane_alu.sv
module simd_dual_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int LANES   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] lane_y;
  logic [LANES-1:0]  lane_sat_hi;
  logic [LANES-1:0]  lane_sat_lo;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane #(.W(LANE_W)) u_lane (
      .op     (op),
      .a      (src_a[g*LANE_W +: LANE_W]),
      .b      (src_b[g*LANE_W +: LANE_W]),
      .y      (lane_y[g*LANE_W +: LANE_W]),
      .sat_hi (lane_sat_hi[g]),
      .sat_lo (lane_sat_lo[g])
    );
  end

  simd_out_stage #(.W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d         (lane_y),
    .out_valid (out_valid),
    .q         (result)
  );

endmodule

// File: rtl/simd_dual_lane_alu_chk.sv
module simd_dual_lane_alu_chk
  import simd_alu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int LANES   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [LANES-1:0]  lane_sat_hi,
  input logic [LANES-1:0]  lane_sat_lo
);

  localparam int LANE_W = DATA_W / LANES;
  localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

  if (REG_OUT) begin : g_seq
    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
    // R8
    undef_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op >= OP_W'(NUM_OPS)) |=> (result == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
      // R2
      sat_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lane_sat_hi[g], lane_sat_lo[g]}));
      // R2
      ssat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_SADD_SAT || op == OP_SSUB_SAT) && lane_sat_lo[g])
        |=> (result[g*LANE_W +: LANE_W] == SMIN));
      // R2
      ssat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_SADD_SAT || op == OP_SSUB_SAT) && lane_sat_hi[g])
        |=> (result[g*LANE_W +: LANE_W] == SMAX));
      // R3
      usat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_UADD_SAT && lane_sat_hi[g])
        |=> (result[g*LANE_W +: LANE_W] == {LANE_W{1'b1}}));
      // R3
      usat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_USUB_SAT && lane_sat_lo[g])
        |=> (result[g*LANE_W +: LANE_W] == '0));
      // R5
      umean_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_UAVG_ADD) |=>
        (result[g*LANE_W +: LANE_W] <= $past(src_a[g*LANE_W +: LANE_W]) ||
         result[g*LANE_W +: LANE_W] <= $past(src_b[g*LANE_W +: LANE_W])));
    end
  end

endmodule

bind simd_dual_lane_alu simd_dual_lane_alu_chk #(
  .DATA_W(DATA_W), .LANES(LANES), .REG_OUT(REG_OUT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .op          (op),
  .src_a       (src_a),
  .src_b       (src_b),
  .out_valid   (out_valid),
  .result      (result),
  .lane_sat_hi (lane_sat_hi),
  .lane_sat_lo (lane_sat_lo)
);

// File: tb/tb_simd_dual_lane_alu.sv
`timescale 1ns/1ps
module tb_simd_dual_lane_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd_dual_lane_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
  );

  // {op, a, b, expected}
  localparam int NV = 12;
  localparam logic [195:0] VEC [NV] = '{
    {4'd0, 64'h00000001_FFFFFFFF, 64'h00000002_00000001, 64'h00000003_00000000},
    {4'd1, 64'h00000000_00000005, 64'h00000001_00000007, 64'hFFFFFFFF_FFFFFFFE},
    {4'd2, 64'h80000000_7FFFFFFF, 64'h80000000_00000001, 64'h80000000_7FFFFFFF},
    {4'd2, 64'h80000000_80000000, 64'h80000000_80000000, 64'h80000000_80000000},
    {4'd4, 64'h7FFFFFFF_80000000, 64'hFFFFFFFF_00000001, 64'h7FFFFFFF_80000000},
    {4'd3, 64'hFFFFFFF0_00000010, 64'h00000020_00000020, 64'hFFFFFFFF_00000030},
    {4'd5, 64'h00000005_00000009, 64'h00000006_00000004, 64'h00000000_00000005},
    {4'd6, 64'hFFFFFFFF_7FFFFFFF, 64'h00000000_7FFFFFFF, 64'hFFFFFFFF_7FFFFFFF},
    {4'd7, 64'hFFFFFFFF_00000003, 64'hFFFFFFFF_00000004, 64'hFFFFFFFF_00000003},
    {4'd8, 64'h80000000_00000003, 64'h7FFFFFFF_00000000, 64'h80000000_00000001},
    {4'd9, 64'h00000000_00000008, 64'h00000001_00000002, 64'hFFFFFFFF_00000003},
    {4'd12, 64'h12345678_9ABCDEF0, 64'h0FEDCBA9_87654321, 64'h00000000_00000000}
  };

  localparam string VREQ [NV] = '{"R1", "R1", "R2", "R2", "R2", "R3", "R3",
                                  "R4", "R5", "R6", "R7", "R8"};

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Reference lane model at 64-bit precision
  function automatic logic [31:0] ref_lane(input logic [3:0] f, input logic [31:0] x, input logic [31:0] z);
    longint sx = longint'($signed(x));
    longint sz = longint'($signed(z));
    longint ux = longint'({32'd0, x});
    longint uz = longint'({32'd0, z});
    longint t;
    case (f)
      4'd0: t = ux + uz;
      4'd1: t = ux - uz;
      4'd2, 4'd4: begin
        t = (f == 4'd2) ? sx + sz : sx - sz;
        if (t > 64'sd2147483647) t = 64'sd2147483647;
        if (t < -64'sd2147483648) t = -64'sd2147483648;
      end
      4'd3: begin t = ux + uz; if (t > 64'sd4294967295) t = 64'sd4294967295; end
      4'd5: begin t = ux - uz; if (t < 0) t = 0; end
      4'd6: t = (sx + sz) >>> 1;
      4'd7: t = (ux + uz) / 2;
      4'd8: t = (sx - sz) >>> 1;
      4'd9: t = ((ux - uz) & 64'h1_FFFF_FFFF) >> 1;
      default: t = 0;
    endcase
    return t[31:0];
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h7FFFFFFF;
      3: return 32'h80000000;
      4: return 32'hFFFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  // Called at a falling edge; result is sampled one full cycle later
  task automatic issue(input logic [3:0] f, input logic [63:0] a, input logic [63:0] b);
    in_valid = 1'b1; op = f; src_a = a; src_b = b;
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 result", result, 64'h0);
    check("R11 out_valid", {63'd0, out_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][195:192], VEC[i][191:128], VEC[i][127:64]);
      check(VREQ[i], result, VEC[i][63:0]);
      // R9: valid follows accepted input
      check("R9 out_valid", {63'd0, out_valid}, 64'h1);
    end

    // R4: signed mean of -1 and 0 in both lanes
    issue(4'd6, 64'hFFFFFFFF_FFFFFFFF, 64'h0);
    check("R4 mean(-1,0)", result, 64'hFFFFFFFF_FFFFFFFF);
    // R7: 0-1 halving in both lanes
    issue(4'd9, 64'h0, 64'h00000001_00000001);
    check("R7 0-1", result, 64'hFFFFFFFF_FFFFFFFF);
    // R2: subtract clamp in lane 1 only
    issue(4'd4, 64'h7FFFFFFF_00000003, 64'hFFFFFFFF_00000001);
    check("R2 lane1 clamp", result, 64'h7FFFFFFF_00000002);

    // R10: inputs change while in_valid is low
    in_valid = 1'b0; op = 4'd0; src_a = 64'h1111_1111_1111_1111; src_b = 64'h2222_2222_2222_2222;
    @(negedge clk);
    check("R10 hold", result, 64'h7FFFFFFF_00000002);
    check("R9 idle valid", {63'd0, out_valid}, 64'h0);
    op = 4'd1;
    @(negedge clk);
    check("R10 hold2", result, 64'h7FFFFFFF_00000002);

    // R1..R8 random vectors against the model
    for (int i = 0; i < 10000; i++) begin
      logic [3:0]  f;
      logic [63:0] a, b, e;
      f = 4'($urandom % 16);
      a = {pick(), pick()};
      b = {pick(), pick()};
      e = {ref_lane(f, a[63:32], b[63:32]), ref_lane(f, a[31:0], b[31:0])};
      issue(f, a, b);
      check($sformatf("R1-model op%0d", f), result, e);
    end

    // R11: reset in mid-run clears the outputs
    rst_n = 1'b0;
    #1;
    check("R11 mid result", result, 64'h0);
    check("R11 mid out_valid", {63'd0, out_valid}, 64'h0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule